// File: doc/BRIEF.md
# Single-Byte SPI Serial Port

This block moves one byte at a time over a synchronous serial link and can play either side of the link. A small register port lets software pick master or slave operation, enable the select input and the serial output, load the byte to send, and arm the transfer by writing a trigger bit. One shift register carries both directions: the outgoing byte leaves most significant bit first on the serial output while the incoming byte fills in behind it. There is no buffering, so software must service the port after every byte. An interrupt flag is raised only when a byte has finished. It is cleared by writing 1 to it.

As master, the port generates the serial clock from the system clock. Each clock level lasts a programmable number of system cycles, and the clock idles low. As slave, the external serial clock and the active-low select are resynchronised into the system clock. Clock edges are taken only while the byte is armed and, when the select function is on, only while select is low. If select is released partway through a byte, the byte is abandoned, the outgoing data is put back and the port stays armed for a retry. The register port is a plain single-cycle write and combinational read; no data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `spi_byte_port`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0, `sclk_out` is 0 and `sclk_oe` is 0.
- R2: Register layout:
  - Address 0 is the control register. Bit 0 enables the port, bit 1 selects master (1) or slave (0), bit 2 enables the select input, bit 3 enables the serial output, and bit 4 is the trigger.
  - Writing 1 to the trigger with bit 0 also 1 while the port is idle arms a byte. Bit 4 then reads 1 until the byte completes.
  - A trigger write with bit 0 at 0 leaves bit 4 at 0. Writing the control register with bit 0 at 0 drops any armed byte.
- R3: Master mode:
  - After arming, `sclk_out` gives exactly 8 high pulses. Each level lasts (divider + 1) system clocks, where the divider is the register at address 3.
  - The clock ends low.
  - The byte at address 2 leaves on `sout` MSB first, each bit stable across its rising edge.
  - `sin` is sampled on each rising edge, MSB first, and address 2 reads the received byte afterwards.
- R4: Slave mode:
  - `sout` holds the MSB of the armed byte before the first external rising edge and moves to the next bit after each falling edge.
  - `sin` is sampled on each rising edge.
  - The byte completes on the 8th rising edge, and address 2 then reads the received byte.
- R5: In slave mode with the select input enabled, `sclk_in` edges while `sel_n` is high do not shift. The byte stays armed, the irq flag stays 0, and address 2 keeps the loaded byte.
- R6: If `sel_n` rises (with the select input enabled) after one or more bits of a slave byte:
  - The bit count resets and address 2 returns to the byte that was armed.
  - Bit 4 stays 1 and the irq flag stays 0.
  - A following complete byte sends the original data.
- R7: The irq flag (address 1 bit 0, mirrored on `irq`) is set only when a byte completes and is never set on arming. Writing 1 to address 1 bit 0 clears it.
- R8: Writes to address 2 while a byte is armed have no effect.
- R9: Pin gating:
  - `sout_oe` equals control bits 0 and 3 together.
  - `rdy_out` is 1 only for an armed slave that has not begun shifting and has the select input disabled; enabling the select input forces it to 0.
- R10: In slave mode with the select input disabled, bytes transfer whatever the level of `sel_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Byte-complete interrupt flag |
| sclk_in | input | 1 | Serial clock from an external master |
| sclk_out | output | 1 | Serial clock generated in master mode |
| sclk_oe | output | 1 | Drive enable for `sclk_out` |
| sin | input | 1 | Serial data in |
| sout | output | 1 | Serial data out |
| sout_oe | output | 1 | Drive enable for `sout` |
| sel_n | input | 1 | Active-low slave select |
| rdy_out | output | 1 | Slave ready indication when the select input is unused |

## Verification
The properties assume that software leaves the mode bits and the divider alone while a byte is armed. They also assume that in slave mode each `sclk_in` level lasts several system clocks longer than the synchroniser depth, and that `sel_n` changes only while `sclk_in` is low. The stimulus keeps within these limits:
- every external clock phase lasts six system cycles;
- `sin` changes only at the start of a low phase;
- `sel_n` is moved only with the clock low, with a few idle cycles before the first edge;
- randomised bytes and divider values are applied only between armed bytes.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam int REG_W = 8;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;
  localparam int TRIG_BIT = 4;
  typedef struct packed {
    logic sout_en;
    logic sel_en;
    logic master;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= {STAGES{INIT}};
    else        ff <= {ff[STAGES-2:0], d};
  end
  assign q = ff[STAGES-1];
endmodule

// File: rtl/spi_clk_gen.sv
module spi_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             sclk,
  output logic             rise_p,
  output logic             fall_p
);
  logic [DIV_W-1:0] tcnt;
  logic             tick;

  assign tick   = run && (tcnt == half);
  assign rise_p = tick & ~sclk;
  assign fall_p = tick & sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      tcnt <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      tcnt <= '0;
      sclk <= ~sclk;
    end else begin
      tcnt <= tcnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_data,
  input  logic          arm,
  input  logic          restore,
  input  logic          clear,
  input  logic          sample,
  input  logic          drive,
  input  logic          sin,
  output logic [W-1:0]  shreg,
  output logic [CW-1:0] cnt,
  output logic          sout_bit
);
  logic [W-1:0] saved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      saved    <= '0;
      cnt      <= '0;
      sout_bit <= 1'b0;
    end else if (load) begin
      shreg    <= load_data;
      saved    <= load_data;
      sout_bit <= load_data[W-1];
      cnt      <= '0;
    end else if (arm) begin
      saved    <= shreg;
      sout_bit <= shreg[W-1];
      cnt      <= '0;
    end else if (restore) begin
      shreg    <= saved;
      sout_bit <= saved[W-1];
      cnt      <= '0;
    end else begin
      if (sample) shreg <= {shreg[W-2:0], sin};
      if (clear)       cnt <= '0;
      else if (sample) cnt <= cnt + CW'(1);
      if (drive) sout_bit <= shreg[W-1];
    end
  end
endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
  import spi_byte_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq,
  input  logic             sclk_in,
  output logic             sclk_out,
  output logic             sclk_oe,
  input  logic             sin,
  output logic             sout,
  output logic             sout_oe,
  input  logic             sel_n,
  output logic             rdy_out
);
  localparam int CW = $clog2(DATA_W + 1);

  ctrl_t             ctrl;
  logic              busy, irq_q;
  logic [DIV_W-1:0]  div_q;
  logic              sclk_s, sclk_d, sel_s;
  logic              s_rise, s_fall, sel_ok;
  logic              g_sclk, g_rise, g_fall;
  logic              m_run, slave_go;
  logic              sample, drive, abort, done, arm, load, wr_ctrl;
  logic [DATA_W-1:0] shreg;
  logic [CW-1:0]     cnt;
  logic              sout_bit;

  spi_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .d(sclk_in), .q(sclk_s));
  spi_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_sel (
    .clk(clk), .rst_n(rst_n), .d(sel_n), .q(sel_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign s_rise   = sclk_s & ~sclk_d;
  assign s_fall   = ~sclk_s & sclk_d;
  assign sel_ok   = ~ctrl.sel_en | ~sel_s;
  assign m_run    = ctrl.en & ctrl.master & busy;
  assign slave_go = ctrl.en & ~ctrl.master & busy & sel_ok;

  spi_clk_gen #(.DIV_W(DIV_W)) u_clk_gen (
    .clk(clk), .rst_n(rst_n), .run(m_run), .half(div_q),
    .sclk(g_sclk), .rise_p(g_rise), .fall_p(g_fall));

  assign sample = ctrl.master ? (m_run & g_rise) : (slave_go & s_rise);
  assign drive  = ctrl.master ? (m_run & g_fall) : (slave_go & s_fall);
  assign abort  = ctrl.en & ~ctrl.master & ctrl.sel_en & busy & sel_s & (cnt != '0);
  assign done   = ctrl.master ? (m_run & g_fall & (cnt == CW'(DATA_W)))
                              : (slave_go & s_rise & (cnt == CW'(DATA_W - 1)));

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign arm     = wr_ctrl & reg_wdata[TRIG_BIT] & reg_wdata[0] & ~busy;
  assign load    = reg_wr && (reg_addr == A_DATA) && !busy;

  spi_shift_core #(.W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(reg_wdata[DATA_W-1:0]),
    .arm(arm), .restore(abort), .clear(done), .sample(sample), .drive(drive),
    .sin(sin), .shreg(shreg), .cnt(cnt), .sout_bit(sout_bit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      busy  <= 1'b0;
      irq_q <= 1'b0;
      div_q <= '0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(reg_wdata[3:0]);
      if (arm)                          busy <= 1'b1;
      else if (done)                    busy <= 1'b0;
      else if (wr_ctrl && !reg_wdata[0]) busy <= 1'b0;
      if (done) irq_q <= 1'b1;
      else if (reg_wr && reg_addr == A_STAT && reg_wdata[0]) irq_q <= 1'b0;
      if (reg_wr && reg_addr == A_DIV) div_q <= reg_wdata[DIV_W-1:0];
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = {3'b000, busy, ctrl};
      A_STAT:  reg_rdata = {7'b0, irq_q};
      A_DATA:  reg_rdata = REG_W'(shreg);
      default: reg_rdata = REG_W'(div_q);
    endcase
  end

  assign irq      = irq_q;
  assign sclk_oe  = ctrl.en & ctrl.master;
  assign sclk_out = sclk_oe & g_sclk;
  assign sout     = sout_bit;
  assign sout_oe  = ctrl.en & ctrl.sout_en;
  assign rdy_out  = ctrl.en & ~ctrl.master & ~ctrl.sel_en & busy & (cnt == '0);
endmodule

// File: rtl/spi_byte_port_chk.sv
module spi_byte_port_chk #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          en,
  input logic          master,
  input logic          sel_en,
  input logic          sel_s,
  input logic          busy,
  input logic          irq,
  input logic          done,
  input logic          sample,
  input logic          restore,
  input logic [CW-1:0] cnt,
  input logic [W-1:0]  shreg,
  input logic          sclk_out
);
  p_irq_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(busy));

  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done && !reg_wr |=> busy);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(W));

  p_master_ends_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && master |-> !sclk_out);

  p_deselect_noshift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en && !master && sel_en && sel_s |=> cnt == '0);

  p_abort_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restore && !reg_wr |=> busy && cnt == '0);

  p_data_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !sample && !restore |=> $stable(shreg));
endmodule

bind spi_byte_port spi_byte_port_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .en(ctrl.en), .master(ctrl.master),
  .sel_en(ctrl.sel_en), .sel_s(sel_s), .busy(busy), .irq(irq_q), .done(done),
  .sample(sample), .restore(abort), .cnt(cnt), .shreg(shreg), .sclk_out(sclk_out));

// File: tb/spi_byte_port_bench.sv
module spi_byte_port_bench;
  localparam logic [7:0] C_EN = 8'h01, C_MS = 8'h02, C_SE = 8'h04, C_OE = 8'h08, C_TRIG = 8'h10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq, sclk_out, sclk_oe, sout, sout_oe, rdy_out;
  logic       sclk_in = 1'b0, sin = 1'b0, sel_n = 1'b1;
  int         total = 0, bad = 0, cyc = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  spi_byte_port u_spi_byte_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .sin(sin), .sout(sout), .sout_oe(sout_oe), .sel_n(sel_n), .rdy_out(rdy_out));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int exp_half(input int div);
    return div + 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic ext_pulses(input int n);
    repeat (n) begin idle(6); sclk_in = 1'b1; idle(6); sclk_in = 1'b0; end
  endtask

  // drives one full external byte, captures sout before every rising edge
  task automatic ext_byte(input logic [7:0] stx, output logic [7:0] got);
    got = 8'h00;
    for (int i = 0; i < 8; i++) begin
      sin = stx[7-i];
      idle(6);
      got = {got[6:0], sout};
      sclk_in = 1'b1; idle(6); sclk_in = 1'b0;
    end
    idle(6);
  endtask

  task automatic master_byte(input logic [7:0] tx, input logic [7:0] stx, input int div);
    logic [7:0] got; int pulses, hi, nfall; logic hi_ok, prev;
    wr(2'd3, 8'(div)); wr(2'd2, tx); wr(2'd1, 8'h01);
    sin = stx[7];
    wr(2'd0, C_EN | C_MS | C_OE | C_TRIG);
    #1;
    chk("R2 busy after arm", 32'(reg_rdata[4]), 32'd1);
    chk("R7 no irq at start", 32'(irq), 32'd0);
    got = 0; pulses = 0; hi = 0; nfall = 0; hi_ok = 1'b1; prev = 1'b0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (sclk_out && !prev) begin got = {got[6:0], sout}; pulses++; hi = 1; end
      else if (sclk_out) hi++;
      if (!sclk_out && prev) begin
        if (hi != exp_half(div)) hi_ok = 1'b0;
        nfall++;
        if (nfall < 8) sin = stx[7-nfall];
      end
      prev = sclk_out;
      if (!reg_rdata[4]) break;
    end
    chk("R3 pulse count", 32'(pulses), 32'd8);
    chk("R3 half period", 32'(hi_ok), 32'd1);
    chk("R3 sout MSB first", 32'(got), 32'(tx));
    chk("R3 clock ends low", 32'(sclk_out), 32'd0);
    rd(2'd2, v); chk("R3 received byte", 32'(v), 32'(stx));
    chk("R7 irq at end", 32'(irq), 32'd1);
  endtask

  task automatic slave_byte(input logic [7:0] tx, input logic [7:0] stx,
                            input logic [7:0] extra, input logic sel_lvl);
    logic [7:0] got;
    wr(2'd2, tx); wr(2'd1, 8'h01);
    wr(2'd0, C_EN | C_OE | extra | C_TRIG);
    #1 chk("R7 no irq at slave arm", 32'(irq), 32'd0);
    sel_n = sel_lvl; idle(4);
    ext_byte(stx, got);
    sel_n = 1'b1;
    chk("R4 slave sout MSB first", 32'(got), 32'(tx));
    rd(2'd0, v); chk("R4 busy cleared", 32'(v[4]), 32'd0);
    rd(2'd2, v); chk("R4 slave received", 32'(v), 32'(stx));
    chk("R7 irq slave end", 32'(irq), 32'd1);
  endtask

  initial begin
    logic [7:0] got;
    void'($urandom(32'd2718));
    idle(5); rst_n = 1'b1; idle(1);

    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reset regs", 32'(v), 32'd0);
    end
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 sclk_out", 32'(sclk_out), 32'd0);
    chk("R1 sclk_oe", 32'(sclk_oe), 32'd0);

    wr(2'd0, C_TRIG);
    rd(2'd0, v); chk("R2 trigger ignored when disabled", 32'(v[4]), 32'd0);

    wr(2'd0, C_EN | C_SE | C_OE); #1 chk("R9 sout_oe on", 32'(sout_oe), 32'd1);
    wr(2'd0, C_EN);               #1 chk("R9 sout_oe off", 32'(sout_oe), 32'd0);

    wr(2'd2, 8'h11); wr(2'd0, C_EN | C_TRIG);
    #1 chk("R9 rdy armed slave", 32'(rdy_out), 32'd1);
    wr(2'd2, 8'h5A);
    rd(2'd2, v); chk("R8 data write while busy", 32'(v), 32'h11);
    wr(2'd0, C_EN | C_SE);
    #1 chk("R9 rdy forced low by select", 32'(rdy_out), 32'd0);
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R2 disable drops armed byte", 32'(v[4]), 32'd0);

    master_byte(8'hA5, 8'h3C, 0);
    master_byte(8'h81, 8'h7E, 2);

    slave_byte(8'hC3, 8'h96, C_SE, 1'b0);

    // R5: clocks with select high are ignored
    wr(2'd2, 8'h69); wr(2'd1, 8'h01); wr(2'd0, C_EN | C_SE | C_OE | C_TRIG);
    sel_n = 1'b1; sin = 1'b1;
    ext_pulses(8); idle(6);
    rd(2'd0, v); chk("R5 still armed", 32'(v[4]), 32'd1);
    chk("R5 no irq", 32'(irq), 32'd0);
    rd(2'd2, v); chk("R5 data untouched", 32'(v), 32'h69);

    // R6: abort after three bits, then retry
    sel_n = 1'b0; idle(4); sin = 1'b0;
    ext_pulses(3); sel_n = 1'b1; idle(6);
    rd(2'd0, v); chk("R6 still armed after abort", 32'(v[4]), 32'd1);
    chk("R6 no irq after abort", 32'(irq), 32'd0);
    rd(2'd2, v); chk("R6 data restored", 32'(v), 32'h69);
    sel_n = 1'b0; idle(4);
    ext_byte(8'hB4, got); sel_n = 1'b1;
    chk("R6 retry sends original", 32'(got), 32'h69);
    rd(2'd2, v); chk("R6 retry received", 32'(v), 32'hB4);
    chk("R6 irq after retry", 32'(irq), 32'd1);

    slave_byte(8'h5C, 8'hE1, 8'h00, 1'b1);  // R10

    wr(2'd1, 8'h01);
    rd(2'd1, v); chk("R7 w1c flag", 32'(v), 32'd0);
    chk("R7 w1c pin", 32'(irq), 32'd0);

    for (int n = 0; n < 6; n++)
      master_byte(8'($urandom), 8'($urandom), int'($urandom_range(3, 0)));
    for (int n = 0; n < 6; n++)
      slave_byte(8'($urandom), 8'($urandom), (n % 2 == 0) ? C_SE : 8'h00, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule